// File: doc/BRIEF.md
# Power Management Interrupt Controller

This block collects power-management event pulses from up to `NUM_SRC` sources into a pending (cause) register. A per-source enable (mask) register selects which pending sources raise the single level-sensitive interrupt line to the parent controller. A read-only index register reports the highest-numbered source that is both pending and enabled. A handler can use it to service sources from the top bit downward.

Software reaches the three registers over a simple single-cycle register bus. A request with the write strobe set writes on the clock edge. Read data is combinational from the address. The cause register is plain read/write rather than write-one-to-clear. A write replaces its whole contents, and writing a 1 raises that source. To clear a source, software writes back the cause value with that bit at 0.

Top module: `pm_irq_ctrl`

## Requirements
- R1: After reset, the cause, mask and index registers all read 0 and `irq_o` is low.
- R2: The cause register is at offset 0x50, the mask register at 0x54 and the index register at 0x58. A read of any other offset returns 0, and a write to any other offset changes no register.
- R3: A one-cycle pulse on `evt_i[k]` sets cause bit k at the next clock edge.
- R4: A cause bit stays set until a bus write to 0x50 stores 0 in it. A write to 0x50 replaces the whole register with the write data.
- R5: Writing 1 into a cause bit sets that source pending, the same as a hardware event would.
- R6: When an event and a cause write fall in the same cycle, the write is applied first and the event bit is ORed on top, so the event is not lost.
- R7: A write to 0x54 replaces the mask. A mask bit of 1 enables its source and 0 disables it.
- R8: `irq_o` is high exactly when (cause AND mask) is nonzero. It follows register state in the cycle after the edge that changed it.
- R9: The index register holds the valid flag in bit 31 and the highest pending enabled source number in bits 4:0. All bits read 0 when nothing is pending and enabled.
- R10: A pending source whose mask bit is 0 affects neither `irq_o` nor the index register. Writes to the index register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | Write strobe, valid with request |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Level interrupt to the parent controller |

## Verification
The assertions assume that `evt_i`, the bus strobes, the address and the write data are stable around the rising clock edge. They also assume that `bus_we_i` has meaning only while `bus_req_i` is high. The bench meets both conditions by driving every input on the falling edge. It holds each access for exactly one cycle and gives the event pulses one-cycle width. Random traffic mixes writes to mapped and unmapped offsets with events that often land in the same cycle as a cause write. This is the case that the event-over-write ordering guards.

// File: rtl/pm_irq_pkg.sv
package pm_irq_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CAUSE_OFF = 32'h50;
  localparam int unsigned MASK_OFF  = 32'h54;
  localparam int unsigned INDEX_OFF = 32'h58;
  localparam int unsigned VALID_BIT = 31;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CAUSE,
    SEL_MASK,
    SEL_INDEX
  } reg_sel_e;
endpackage

// File: rtl/pm_irq_cause.sv
module pm_irq_cause #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] cause_o
);
  logic [NUM_SRC-1:0] cause_q, cause_d;

  // write lands first, events OR on top so none is lost
  always_comb begin
    cause_d = wr_en_i ? wdata_i : cause_q;
    cause_d = cause_d | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  a_r3_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && evt_i == '0) |=> $stable(cause_q));

  a_r6_evt_over_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (cause_q == ($past(wdata_i) | $past(evt_i))));
endmodule

// File: rtl/pm_irq_mask.sv
module pm_irq_mask #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_en_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  a_r7_mask_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mask_q == $past(wdata_i)));

  a_r7_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q));
endmodule

// File: rtl/pm_irq_prio.sv
module pm_irq_prio #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  // ascending scan, last hit wins -> highest bit has priority
  always_comb begin
    idx_o = '0;
    for (int unsigned i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |pend_i;
endmodule

// File: rtl/pm_irq_ctrl.sv
module pm_irq_ctrl
  import pm_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  evt_i,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  reg_sel_e           sel;
  logic               wr_cause, wr_mask;
  logic [NUM_SRC-1:0] cause, mask, pend;
  logic               top_valid;
  logic [IDX_W-1:0]   top_idx;

  always_comb begin
    if      (bus_addr_i == ADDR_W'(CAUSE_OFF)) sel = SEL_CAUSE;
    else if (bus_addr_i == ADDR_W'(MASK_OFF))  sel = SEL_MASK;
    else if (bus_addr_i == ADDR_W'(INDEX_OFF)) sel = SEL_INDEX;
    else                                       sel = SEL_NONE;
  end

  assign wr_cause = bus_req_i && bus_we_i && (sel == SEL_CAUSE);
  assign wr_mask  = bus_req_i && bus_we_i && (sel == SEL_MASK);

  pm_irq_cause #(.NUM_SRC(NUM_SRC)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .wr_en_i (wr_cause),
    .wdata_i (bus_wdata_i[NUM_SRC-1:0]),
    .cause_o (cause)
  );

  pm_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_mask),
    .wdata_i (bus_wdata_i[NUM_SRC-1:0]),
    .mask_o  (mask)
  );

  assign pend = cause & mask;

  pm_irq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .pend_i  (pend),
    .valid_o (top_valid),
    .idx_o   (top_idx)
  );

  assign irq_o = top_valid;

  always_comb begin
    bus_rdata_o = '0;
    unique case (sel)
      SEL_CAUSE: bus_rdata_o[NUM_SRC-1:0] = cause;
      SEL_MASK:  bus_rdata_o[NUM_SRC-1:0] = mask;
      SEL_INDEX: begin
        bus_rdata_o[VALID_BIT]   = top_valid;
        bus_rdata_o[IDX_W-1:0]   = top_valid ? top_idx : '0;
      end
      default:   bus_rdata_o = '0;
    endcase
  end

  a_r8_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (pend != '0));

  a_r9_idx_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_valid |-> (pend[top_idx] && ((pend >> top_idx) == NUM_SRC'(1))));

  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cause == '0 && mask == '0));
endmodule

// File: tb/pm_irq_ctrl_test.sv
module pm_irq_ctrl_test;
  localparam int CLK_P = 10;
  localparam int N = 32;

  logic        clk = 0, rst_n = 0;
  logic [N-1:0] evt = '0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;

  int checks = 0, errors = 0;
  logic [31:0] m_cause = 0, m_mask = 0;

  always #(CLK_P/2) clk = ~clk;

  pm_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .bus_req_i(req),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] m_index();
    logic [31:0] p = m_cause & m_mask;
    for (int i = N - 1; i >= 0; i--)
      if (p[i]) return 32'h8000_0000 | 32'(i);
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h50:   return m_cause;
      8'h54:   return m_mask;
      8'h58:   return m_index();
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one bus cycle; outputs compared against model before the edge
  task automatic cyc(logic [N-1:0] e, logic rq, logic w, logic [7:0] a,
                     logic [31:0] d, string tag = "");
    string t;
    @(negedge clk);
    evt = e; req = rq; we = w; addr = a; wdata = d;
    #1;
    if (tag != "") t = tag;
    else case (a)
      8'h50: t = "R4"; 8'h54: t = "R7"; 8'h58: t = "R9"; default: t = "R2";
    endcase
    chk(t, rdata, m_read(a));
    chk("R8", {31'b0, irq}, {31'b0, (m_cause & m_mask) != 0});
    @(posedge clk);
    if (rq && w && a == 8'h50) m_cause = d;
    if (rq && w && a == 8'h54) m_mask = d;
    m_cause = m_cause | e;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cyc('0, 1, 0, 8'h50, 0, "R1");
    cyc('0, 1, 0, 8'h54, 0, "R1");
    cyc('0, 1, 0, 8'h58, 0, "R1");
    // R3 event sets bit, masked: R10 no irq
    cyc(32'h20, 0, 0, 8'h00, 0);
    cyc('0, 1, 0, 8'h50, 0, "R3");
    cyc('0, 1, 0, 8'h58, 0, "R10");
    // R7 enable, R9 index
    cyc('0, 1, 1, 8'h54, 32'h0000_0120, "R7");
    cyc('0, 1, 0, 8'h58, 0, "R9");
    // R5 software set of high bit takes priority
    cyc('0, 1, 1, 8'h50, 32'h0000_0120, "R5");
    cyc('0, 1, 0, 8'h58, 0, "R5");
    // R6 event in same cycle as clearing write
    cyc(32'h1, 1, 1, 8'h50, 32'h0, "R6");
    cyc('0, 1, 0, 8'h50, 0, "R6");
    // R2 unmapped write ignored, index write ignored (R10)
    cyc('0, 1, 1, 8'h60, 32'hFFFF_FFFF, "R2");
    cyc('0, 1, 1, 8'h58, 32'hFFFF_FFFF, "R10");
    cyc('0, 1, 0, 8'h54, 0, "R2");
    cyc('0, 1, 0, 8'h58, 0, "R10");
    // R4 bit stays until written 0
    cyc(32'h8000_0000, 0, 0, 0, 0);
    repeat (3) cyc('0, 1, 0, 8'h50, 0, "R4");
    cyc('0, 1, 1, 8'h50, 32'h0, "R4");
    cyc('0, 1, 0, 8'h50, 0, "R4");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] e;
      logic [7:0] a;
      logic [2:0] s;
      e = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : '0;
      s = 3'($urandom_range(0, 4));
      case (s)
        0: a = 8'h50; 1: a = 8'h54; 2: a = 8'h58; 3: a = 8'h5C;
        default: a = 8'h00;
      endcase
      cyc(e, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, a,
          $urandom & $urandom);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule